// File: doc/BRIEF.md
# Two-Buffer Alternating DMA Channel

This block is one DMA channel that moves beats between a fixed peripheral address and memory. It owns two buffer descriptors, each with its own start address, address-high bits and beat count, and it works through them in turn: when the active buffer runs out, the channel marks it done, retires it and moves to the other one. Software fills one buffer while the channel drains the other. This keeps a stream going without gaps, provided each buffer is refilled and re-enabled before the channel comes back to it.

Software reaches the channel through a small register window. The mode word has one read view and two write ports. The port at offset 0x00 sets every bit written as 1, and the port at offset 0x04 clears every bit written as 1. Software can therefore change single bits without a read-modify-write. Each beat is started by a peripheral request and then handed to memory with a request/grant handshake. The mode word reports per-buffer done flags, which buffer is active and whether the channel has come to rest after its run bit was dropped. An interrupt line is raised while any done flag is set and interrupts are enabled.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset, every register reads 0 except the mode word, which reads 0x00000040 (only the halted bit). `xfer_req` and `irq` are low.
- R2: A write to offset 0x00 sets the mode bits written as 1, and a write to offset 0x04 clears them. Only the bits in mask 0x00FFBFAF are writable. Bit 4 (active buffer) and bit 6 (halted) ignore writes, and bits 14 and 31:24 read 0. Offset 0x04 reads 0.
- R3: The window is laid out as follows: 0x08 is the peripheral address, 0x0C and 0x14 are the buffer 0 and buffer 1 start addresses, and 0x10 and 0x18 are the buffer 0 and buffer 1 counts. A count register keeps the count in bits [CNT_W-1:0] and the address-high bits in 19:16, and every other bit reads 0.
- R4: A beat is requested in the cycle after all of the following hold together: run bit 5 is set, the active buffer's enable is set (bit 0 for buffer 0, bit 2 for buffer 1), its count is non-zero, `periph_req` is high and no beat is pending. `xfer_req` and `xfer_mem_addr` then hold steady until `xfer_gnt` is seen.
- R5: At each granted beat, the active buffer's start address grows by the beat size and its count drops by 1. The beat size comes from mode bits 10:9: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. Reading the count therefore gives the beats that remain.
- R6: When the active count reaches zero, the channel sets that buffer's done flag (bit 1 or bit 3), clears its enable and toggles bit 4. It then goes on with the other buffer if that buffer is enabled, and otherwise it stays idle.
- R7: An enabled active buffer whose count is zero completes as in R6 without issuing any beat, as long as the run bit is set.
- R8: When the run bit is cleared, a pending beat still completes. Bit 6 reads 0 while the run bit is set or a beat is pending, and 1 otherwise. No new beat starts while the run bit is clear.
- R9: `irq` is high exactly when bit 7 is set and done bit 1 or done bit 3 is set. Writing 1 to a done position at offset 0x04 clears that done flag.
- R10: `xfer_mem_addr` is the active buffer's {count bits 19:16, start}. `xfer_dev_addr` is {mode bits 23:20, peripheral address}. `xfer_width` follows mode bits 10:9, and `xfer_dir` follows mode bit 12.
- R11: No beat is requested while `periph_req` is low, and the count is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| periph_req | input | 1 | Peripheral asks for a beat |
| xfer_req | output | 1 | Beat pending on the memory side |
| xfer_gnt | input | 1 | Memory side accepts the pending beat |
| xfer_mem_addr | output | 36 | Memory address of the pending beat |
| xfer_dev_addr | output | 36 | Peripheral address for the beats |
| xfer_width | output | 2 | Beat width code |
| xfer_dir | output | 1 | Direction bit from the mode word |
| irq | output | 1 | Buffer completion interrupt |

## Verification
The bench builds the channel with CNT_W=8, so a write of all ones to a count register must read back with the count masked to 0xFF next to the address-high nibble. This makes the count width visible at the register window. Small counts of 0 to 4 beats bring a whole buffer hand-over within a few dozen cycles. In that time the bench can cover a full alternation across both buffers, the zero-count completion, an idle hand-over to a disabled buffer and a halt with one beat held in flight by a withheld grant.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  localparam int REG_W   = 32;
  localparam int AHI_W   = 4;
  localparam int OFS_W   = 5;
  localparam int NBUF    = 2;
  localparam int AHI_LO  = 16;
  localparam int MEM_AW  = REG_W + AHI_W;

  localparam logic [OFS_W-1:0] OFS_MODE_SET = 5'h00;
  localparam logic [OFS_W-1:0] OFS_MODE_CLR = 5'h04;
  localparam logic [OFS_W-1:0] OFS_DEV      = 5'h08;
  localparam logic [OFS_W-1:0] OFS_START0   = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_COUNT0   = 5'h10;
  localparam logic [OFS_W-1:0] OFS_START1   = 5'h14;
  localparam logic [OFS_W-1:0] OFS_COUNT1   = 5'h18;

  localparam int B_EN0   = 0;
  localparam int B_DONE0 = 1;
  localparam int B_EN1   = 2;
  localparam int B_DONE1 = 3;
  localparam int B_ACT   = 4;
  localparam int B_GO    = 5;
  localparam int B_HALT  = 6;
  localparam int B_IE    = 7;
  localparam int B_WID   = 9;
  localparam int B_DIR   = 12;
  localparam int B_DHI   = 20;

  localparam logic [REG_W-1:0] MODE_WMASK = 32'h00FF_BFAF;

  typedef enum logic [1:0] {
    WID_BYTE = 2'd0,
    WID_HALF = 2'd1,
    WID_WORD = 2'd2,
    WID_RSVD = 2'd3
  } wid_e;

  function automatic logic [2:0] beat_bytes(input logic [1:0] wid);
    if (wid == WID_BYTE)      return 3'd1;
    else if (wid == WID_HALF) return 3'd2;
    else                      return 3'd4;
  endfunction

  function automatic logic [OFS_W-1:0] start_ofs(input int idx);
    return (idx == 0) ? OFS_START0 : OFS_START1;
  endfunction

  function automatic logic [OFS_W-1:0] count_ofs(input int idx);
    return (idx == 0) ? OFS_COUNT0 : OFS_COUNT1;
  endfunction

  function automatic int en_pos(input logic idx);
    return idx ? B_EN1 : B_EN0;
  endfunction

  function automatic int done_pos(input logic idx);
    return idx ? B_DONE1 : B_DONE0;
  endfunction
endpackage

// File: rtl/pp_dma_buf.sv
module pp_dma_buf
  import pp_dma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_we,
  input  logic             count_we,
  input  logic [REG_W-1:0] wdata,
  input  logic             adv,
  input  logic [2:0]       step,
  output logic [REG_W-1:0] start_q,
  output logic [CNT_W-1:0] count_q,
  output logic [AHI_W-1:0] ahi_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      count_q <= '0;
      ahi_q   <= '0;
    end else begin
      if (start_we)  start_q <= wdata;
      else if (adv)  start_q <= start_q + REG_W'(step);
      if (count_we) begin
        count_q <= wdata[CNT_W-1:0];
        ahi_q   <= wdata[AHI_LO +: AHI_W];
      end else if (adv) begin
        count_q <= count_q - CNT_W'(1);
      end
    end
  end

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !count_we |-> count_q != '0);
endmodule

// File: rtl/pp_dma_mode.sv
module pp_dma_mode
  import pp_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [REG_W-1:0] wdata,
  input  logic             finish,
  output logic [REG_W-1:0] mode_q,
  output logic             act_q
);
  logic [REG_W-1:0] hw_nxt;
  logic [REG_W-1:0] nxt;

  always_comb begin
    hw_nxt = mode_q;
    if (finish) begin
      hw_nxt[en_pos(act_q)]   = 1'b0;
      hw_nxt[done_pos(act_q)] = 1'b1;
    end
    nxt = hw_nxt;
    if (set_we) nxt = nxt | (wdata & MODE_WMASK);
    if (clr_we) nxt = nxt & ~(wdata & MODE_WMASK);
    nxt = nxt & MODE_WMASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      act_q  <= 1'b0;
    end else begin
      mode_q <= nxt;
      if (finish) act_q <= !act_q;
    end
  end

  assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q[B_DONE0]) |-> $past(finish && !act_q) || $past(set_we && wdata[B_DONE0]));

  assert_act_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(finish));
endmodule

// File: rtl/pp_dma_seq.sv
module pp_dma_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic cur_en,
  input  logic cur_zero,
  input  logic cur_one,
  input  logic periph_req,
  input  logic gnt,
  output logic pend_q,
  output logic beat_done,
  output logic finish,
  output logic halted
);
  logic issue;
  logic empty_done;

  assign issue      = go && cur_en && !cur_zero && periph_req && !pend_q;
  assign beat_done  = pend_q && gnt;
  assign empty_done = go && cur_en && cur_zero && !pend_q;
  assign finish     = (beat_done && cur_one) || empty_done;
  assign halted     = !go && !pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (issue)     pend_q <= 1'b1;
    else if (beat_done) pend_q <= 1'b0;
  end

  assert_halt_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !go && !pend_q |=> !pend_q);

  assert_zero_nobeat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    empty_done |=> !pend_q);
endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan
  import pp_dma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              periph_req,
  output logic              xfer_req,
  input  logic              xfer_gnt,
  output logic [MEM_AW-1:0] xfer_mem_addr,
  output logic [MEM_AW-1:0] xfer_dev_addr,
  output logic [1:0]        xfer_width,
  output logic              xfer_dir,
  output logic              irq
);
  logic [REG_W-1:0] mode_q;
  logic             act_q;
  logic [REG_W-1:0] dev_q;
  logic             pend_q, beat_done, finish, halted;
  logic [2:0]       step;
  logic             cur_en;
  logic [CNT_W-1:0] cur_cnt;
  logic [REG_W-1:0] mode_view;

  logic [REG_W-1:0] b_start [NBUF];
  logic [CNT_W-1:0] b_count [NBUF];
  logic [AHI_W-1:0] b_ahi   [NBUF];

  assign step = beat_bytes(mode_q[B_WID +: 2]);

  pp_dma_mode u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (reg_we && reg_addr == OFS_MODE_SET),
    .clr_we (reg_we && reg_addr == OFS_MODE_CLR),
    .wdata  (reg_wdata),
    .finish (finish),
    .mode_q (mode_q),
    .act_q  (act_q)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    pp_dma_buf #(.CNT_W(CNT_W)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_we (reg_we && reg_addr == start_ofs(g)),
      .count_we (reg_we && reg_addr == count_ofs(g)),
      .wdata    (reg_wdata),
      .adv      (beat_done && (act_q == 1'(g))),
      .step     (step),
      .start_q  (b_start[g]),
      .count_q  (b_count[g]),
      .ahi_q    (b_ahi[g])
    );
  end

  assign cur_en  = mode_q[en_pos(act_q)];
  assign cur_cnt = b_count[act_q];

  pp_dma_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (mode_q[B_GO]),
    .cur_en     (cur_en),
    .cur_zero   (cur_cnt == '0),
    .cur_one    (cur_cnt == CNT_W'(1)),
    .periph_req (periph_req),
    .gnt        (xfer_gnt),
    .pend_q     (pend_q),
    .beat_done  (beat_done),
    .finish     (finish),
    .halted     (halted)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                             dev_q <= '0;
    else if (reg_we && reg_addr == OFS_DEV) dev_q <= reg_wdata;
  end

  always_comb begin
    mode_view         = mode_q;
    mode_view[B_ACT]  = act_q;
    mode_view[B_HALT] = halted;
  end

  always_comb begin
    case (reg_addr)
      OFS_MODE_SET: reg_rdata = mode_view;
      OFS_DEV:      reg_rdata = dev_q;
      OFS_START0:   reg_rdata = b_start[0];
      OFS_COUNT0:   reg_rdata = {12'd0, b_ahi[0], 16'(b_count[0])};
      OFS_START1:   reg_rdata = b_start[1];
      OFS_COUNT1:   reg_rdata = {12'd0, b_ahi[1], 16'(b_count[1])};
      default:      reg_rdata = '0;
    endcase
  end

  assign xfer_req      = pend_q;
  assign xfer_mem_addr = {b_ahi[act_q], b_start[act_q]};
  assign xfer_dev_addr = {mode_q[B_DHI +: AHI_W], dev_q};
  assign xfer_width    = mode_q[B_WID +: 2];
  assign xfer_dir      = mode_q[B_DIR];
  assign irq           = mode_q[B_IE] && (mode_q[B_DONE0] || mode_q[B_DONE1]);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_gnt && !reg_we |=> xfer_req && $stable(xfer_mem_addr));

  assert_req_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_req) |-> $past(periph_req) && $past(mode_q[B_GO]));

  assert_halt_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_view[B_HALT]) |-> !$past(xfer_req) || $past(xfer_gnt));
endmodule

// File: tb/test_pp_dma_chan.sv
`timescale 1ns/1ps
module test_pp_dma_chan;
  localparam int CNT_W = 8;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        periph_req = 1'b0;
  logic        xfer_req;
  logic        xfer_gnt = 1'b0;
  logic [35:0] xfer_mem_addr;
  logic [35:0] xfer_dev_addr;
  logic [1:0]  xfer_width;
  logic        xfer_dir;
  logic        irq;

  int checks = 0;
  int fails = 0;
  int beat_n = 0;
  logic [35:0] beat_addr [16];
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  pp_dma_chan #(.CNT_W(CNT_W)) i_pp_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .xfer_req(xfer_req), .xfer_gnt(xfer_gnt), .xfer_mem_addr(xfer_mem_addr),
    .xfer_dev_addr(xfer_dev_addr), .xfer_width(xfer_width), .xfer_dir(xfer_dir),
    .irq(irq)
  );

  localparam logic [4:0] V_WA [NV] = '{5'h00, 5'h00, 5'h04, 5'h04, 5'h08,
                                       5'h0C, 5'h10, 5'h14, 5'h18, 5'h04};
  localparam logic [31:0] V_WD [NV] = '{32'h0000_0080, 32'hFFFF_FFDF, 32'h0000_FF00,
                                        32'hFFFF_FFFF, 32'h1234_5678, 32'hA000_0000,
                                        32'hFFFF_FFFF, 32'h0000_1000, 32'h0003_0005,
                                        32'h0000_0000};
  localparam logic [4:0] V_RA [NV] = '{5'h00, 5'h00, 5'h00, 5'h00, 5'h08,
                                       5'h0C, 5'h10, 5'h14, 5'h18, 5'h04};
  localparam logic [31:0] V_EX [NV] = '{32'h0000_00C0, 32'h00FF_BFCF, 32'h00FF_00CF,
                                        32'h0000_0040, 32'h1234_5678, 32'hA000_0000,
                                        32'h000F_00FF, 32'h0000_1000, 32'h0003_0005,
                                        32'h0000_0000};

  always begin
    @(negedge clk);
    #1;
    if (rst_n && xfer_req && xfer_gnt) begin
      if (beat_n < 16) beat_addr[beat_n] = xfer_mem_addr;
      beat_n++;
    end
  end

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rdreg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(3);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rdreg(5'h00, rd); chk("R1 mode", 36'(rd), 36'h40);
    rdreg(5'h10, rd); chk("R1 count0", 36'(rd), 36'h0);
    chk("R1 xfer_req", 36'(xfer_req), 36'h0);
    chk("R1 irq", 36'(irq), 36'h0);

    // R2 / R3 register vectors
    for (int i = 0; i < NV; i++) begin
      wr(V_WA[i], V_WD[i]);
      rdreg(V_RA[i], rd);
      chk((i < 4 || i == 9) ? "R2 vector" : "R3 vector", 36'(rd), 36'(V_EX[i]));
    end

    // R6 R5 R10: full alternation, 32-bit beats
    wr(5'h0C, 32'h100); wr(5'h10, 32'd3);
    wr(5'h14, 32'h200); wr(5'h18, 32'd2);
    wr(5'h00, 32'h485);
    xfer_gnt = 1'b1; periph_req = 1'b1; beat_n = 0;
    wr(5'h00, 32'h20);
    wait_cyc(30);
    periph_req = 1'b0;
    chk("R6 beat count", 36'(beat_n), 36'd5);
    chk("R5 addr0", beat_addr[0], 36'h100);
    chk("R5 addr2", beat_addr[2], 36'h108);
    chk("R6 addr3", beat_addr[3], 36'h200);
    chk("R6 addr4", beat_addr[4], 36'h204);
    rdreg(5'h00, rd); chk("R6 mode after both", 36'(rd), 36'h4AA);
    rdreg(5'h0C, rd); chk("R5 start0 advanced", 36'(rd), 36'h10C);
    rdreg(5'h10, rd); chk("R5 count0 empty", 36'(rd), 36'h0);
    chk("R9 irq set", 36'(irq), 36'h1);
    wr(5'h04, 32'h62A);
    chk("R9 irq cleared", 36'(irq), 36'h0);

    // R8 halt with a beat in flight, 16-bit beats
    wr(5'h00, 32'h200);
    wr(5'h0C, 32'h300); wr(5'h10, 32'd4);
    xfer_gnt = 1'b0; periph_req = 1'b1; beat_n = 0;
    wr(5'h00, 32'h21);
    wait_cyc(4);
    chk("R4 req held", 36'(xfer_req), 36'h1);
    chk("R10 mem addr", xfer_mem_addr, 36'h300);
    chk("R10 width", 36'(xfer_width), 36'h1);
    wr(5'h04, 32'h20);
    rdreg(5'h00, rd); chk("R8 not halted while pending", 36'(rd[6]), 36'h0);
    @(negedge clk) xfer_gnt = 1'b1;
    @(negedge clk) xfer_gnt = 1'b0;
    rdreg(5'h00, rd); chk("R8 halted", 36'(rd[6]), 36'h1);
    rdreg(5'h10, rd); chk("R5 residue", 36'(rd), 36'd3);
    rdreg(5'h0C, rd); chk("R5 start step 2", 36'(rd), 36'h302);
    wait_cyc(10);
    chk("R8 no new beat", 36'(beat_n), 36'd1);

    // R7 zero count, then idle hand-over
    xfer_gnt = 1'b1; beat_n = 0;
    wr(5'h10, 32'd0);
    wr(5'h00, 32'h20);
    wait_cyc(4);
    rdreg(5'h00, rd); chk("R7 zero completion", 36'(rd), 36'h2B2);
    chk("R7 no beat", 36'(beat_n), 36'd0);
    wait_cyc(6);
    chk("R6 idle on disabled", 36'(xfer_req), 36'h0);
    wr(5'h14, 32'h400); wr(5'h18, 32'd1);
    wr(5'h00, 32'h4);
    wait_cyc(8);
    chk("R6 resumed beat", 36'(beat_n), 36'd1);
    chk("R6 resumed addr", beat_addr[0], 36'h400);
    rdreg(5'h00, rd); chk("R6 mode back to 0", 36'(rd), 36'h2AA);

    // R9 interrupt gating
    wr(5'h04, 32'h80); chk("R9 masked", 36'(irq), 36'h0);
    wr(5'h00, 32'h80); chk("R9 unmasked", 36'(irq), 36'h1);
    wr(5'h04, 32'h2);  chk("R9 done1 keeps irq", 36'(irq), 36'h1);
    wr(5'h04, 32'h8);  chk("R9 both clear", 36'(irq), 36'h0);

    // R11 no beat without peripheral request, R10 device side
    periph_req = 1'b0; beat_n = 0;
    wr(5'h0C, 32'h500); wr(5'h10, 32'd2);
    wr(5'h00, 32'h0050_1001);
    wait_cyc(10);
    chk("R11 no req", 36'(xfer_req), 36'h0);
    rdreg(5'h10, rd); chk("R11 count kept", 36'(rd), 36'd2);
    chk("R10 dev addr", xfer_dev_addr, 36'h5_1234_5678);
    chk("R10 dir", 36'(xfer_dir), 36'h1);
    periph_req = 1'b1;
    wait_cyc(12);
    chk("R11 beats after req", 36'(beat_n), 36'd2);
    chk("R5 half step", beat_addr[1], 36'h502);
    rdreg(5'h10, rd); chk("R5 count drained", 36'(rd), 36'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule